// File: doc/BRIEF.md
# Auxiliary Memory Bidirectional DMA Engine

This block copies data between a main memory and an auxiliary memory, in either direction, in 64-bit beats. A host loads three 32-bit registers: the main-memory byte address, the auxiliary byte address, and a count word. The count word carries the byte count and the direction. Each register can be written as a low 16-bit half, a high 16-bit half, or as a full 32-bit word. Writing the count as a low half or as a full word starts the copy. The three registers are readable at all times on output ports, and they show the running addresses and the remaining count while a copy is in progress.

Both memories sit outside the block behind simple synchronous ports with one cycle of read latency. For each beat the engine issues one read on the source port and, in the next cycle, one write of the returned data on the destination port. The block handles two special cases in defined ways:
- **Auxiliary address beyond the installed size:** there is a defined result for each direction.
- **Mirrored configuration mode:** each auxiliary write that falls in the low 4 MB is duplicated 4 MB higher.

While a copy runs, the engine holds a busy flag high. When the copy ends it pulses a completion interrupt for one cycle.

Top module: `aux_dma`

## Requirements
- R1: A low-half write stores `data[15:5]` into bits 15:5 of the selected register and clears bits 4:0. A high-half write stores `data[15:0]` into bits 31:16 and leaves the low half unchanged. A full write stores `data[31:5]` and clears bits 4:0. Selects: `reg_sel_i` 0 = main address, 1 = auxiliary address, 2 = count word. Parts: `reg_part_i` 0 = low, 1 = high, 2 = full.
- R2: A count write with part 0 or part 2 starts a copy. A count write with part 1 does not. Writes with select 3 or part 3 change nothing.
- R3: At start, both addresses are reduced to bits 25:0, so the address space repeats every 64 MB.
- R4: Count word bit 31 selects the direction: 0 copies main to auxiliary, 1 copies auxiliary to main. Bits 30:0 hold the byte count. A beat is one source read followed in the next cycle by one destination write of the returned data, at the current addresses.
- R5: Each beat advances both addresses by 8 and lowers the count by 8. After a copy, each address equals its masked start value plus the count, and the count bits are zero with the direction bit kept.
- R6: `busy_o` is high from the cycle after the starting write until the copy ends. An in-range beat takes 2 cycles, and 3 cycles when mirrored. `irq_o` is high for exactly the one cycle in which `busy_o` has just fallen.
- R7: Auxiliary to main with the masked auxiliary address at or above `AUX_SIZE`: no auxiliary read is issued, and zeros are written to main memory for every beat, still at 2 cycles per beat.
- R8: Main to auxiliary with the masked auxiliary address at or above `AUX_SIZE`: no memory access is made, both addresses advance by the full count at once, the count becomes zero, `irq_o` pulses in the next cycle, and `busy_o` stays low.
- R9: When `mode_i` equals 4, a main-to-auxiliary beat whose auxiliary address is below `0x400000` also writes the same data to that address plus `0x400000`, in the cycle after the first write. No other mode does this.
- R10: A start with a byte count of zero makes no memory access, keeps `busy_o` low, and pulses `irq_o` in the next cycle.
- R11: Any register write made while `busy_o` is high is ignored, including a start request.
- R12: After reset, all registers read zero, `busy_o` and `irq_o` are low, and no memory port is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 main, 1 auxiliary, 2 count |
| reg_part_i | input | 2 | Write part: 0 low half, 1 high half, 2 full word |
| reg_data_i | input | 32 | Write data |
| mode_i | input | 4 | Configuration mode; value 4 enables mirroring |
| main_addr_o | output | 32 | Main address register |
| aux_addr_o | output | 32 | Auxiliary address register |
| count_o | output | 32 | Count word: direction in bit 31, bytes in bits 30:0 |
| busy_o | output | 1 | Copy in progress |
| irq_o | output | 1 | One-cycle completion pulse |
| mm_rd_o | output | 1 | Main memory read request |
| mm_wr_o | output | 1 | Main memory write request |
| mm_addr_o | output | 26 | Main memory byte address |
| mm_wdata_o | output | 64 | Main memory write data |
| mm_rdata_i | input | 64 | Main memory read data, one cycle after the request |
| ax_rd_o | output | 1 | Auxiliary memory read request |
| ax_wr_o | output | 1 | Auxiliary memory write request |
| ax_addr_o | output | 26 | Auxiliary memory byte address |
| ax_wdata_o | output | 64 | Auxiliary memory write data |
| ax_rdata_i | input | 64 | Auxiliary memory read data, one cycle after the request |

## Verification
The assertions assume memories that answer a read exactly one cycle after the request. They also assume that `mode_i` holds still during a copy, and that a programmed byte count is a multiple of 8 (which the alignment rule already enforces). The stimulus meets these assumptions in three ways:
- The bench memory models respond with a fixed one-cycle delay.
- The mode is changed only while the engine is idle.
- Every count reaches the engine through the aligning write paths.

The bench also drives writes during a long copy to probe the ignore rule.

// File: rtl/aux_dma_pkg.sv
package aux_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_MIR} dma_st_t;

  localparam logic [1:0] SEL_MAIN = 2'd0;
  localparam logic [1:0] SEL_AUX  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  localparam logic [1:0] PART_LO   = 2'd0;
  localparam logic [1:0] PART_HI   = 2'd1;
  localparam logic [1:0] PART_FULL = 2'd2;
endpackage

// File: rtl/aux_dma_host_if.sv
module aux_dma_host_if
  import aux_dma_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int ALIGN_B = 5
) (
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [1:0]       reg_part_i,
  input  logic [REG_W-1:0] reg_data_i,
  input  logic             busy_i,
  input  logic [REG_W-1:0] cur_main_i,
  input  logic [REG_W-1:0] cur_aux_i,
  input  logic [REG_W-1:0] cur_cnt_i,
  output logic             ld_main_o,
  output logic             ld_aux_o,
  output logic             ld_cnt_o,
  output logic [REG_W-1:0] ld_val_o,
  output logic             start_o
);
  localparam int HALF_W = REG_W / 2;

  logic [REG_W-1:0] cur;
  logic             accept;

  always_comb begin
    unique case (reg_sel_i)
      SEL_MAIN: cur = cur_main_i;
      SEL_AUX:  cur = cur_aux_i;
      default:  cur = cur_cnt_i;
    endcase
  end

  always_comb begin
    unique case (reg_part_i)
      PART_LO:   ld_val_o = {cur[REG_W-1:HALF_W], reg_data_i[HALF_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
      PART_HI:   ld_val_o = {reg_data_i[HALF_W-1:0], cur[HALF_W-1:0]};
      default:   ld_val_o = {reg_data_i[REG_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
    endcase
  end

  assign accept    = reg_wr_i && !busy_i && (reg_sel_i != 2'd3) && (reg_part_i != 2'd3);
  assign ld_main_o = accept && (reg_sel_i == SEL_MAIN);
  assign ld_aux_o  = accept && (reg_sel_i == SEL_AUX);
  assign ld_cnt_o  = accept && (reg_sel_i == SEL_CNT);
  assign start_o   = ld_cnt_o && (reg_part_i != PART_HI);
endmodule

// File: rtl/aux_dma_engine.sv
module aux_dma_engine
  import aux_dma_pkg::*;
#(
  parameter int          REG_W    = 32,
  parameter int          ADDR_W   = 26,
  parameter int          DATA_W   = 64,
  parameter logic [31:0] AUX_SIZE = 32'h0100_0000,
  parameter logic [31:0] MIR_OFS  = 32'h0040_0000,
  parameter logic [3:0]  MIR_MODE = 4'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              ld_main_i,
  input  logic              ld_aux_i,
  input  logic              ld_cnt_i,
  input  logic [REG_W-1:0]  ld_val_i,
  input  logic [3:0]        mode_i,
  input  logic [DATA_W-1:0] mm_rdata_i,
  output logic [REG_W-1:0]  main_q,
  output logic [REG_W-1:0]  aux_q,
  output logic [REG_W-1:0]  cnt_q,
  output dma_st_t           st_q,
  output logic              oob_q,
  output logic [DATA_W-1:0] hold_q,
  output logic              busy_q,
  output logic              irq_q
);
  localparam int                 BEAT_B = DATA_W / 8;
  localparam int                 CNT_W  = REG_W - 1;
  localparam logic [REG_W-1:0]   AMASK  = (REG_W'(1) << ADDR_W) - REG_W'(1);
  localparam logic [CNT_W-1:0]   BEAT_C = CNT_W'(BEAT_B);
  localparam logic [REG_W-1:0]   BEAT_A = REG_W'(BEAT_B);

  logic [REG_W-1:0] main_m, aux_m, bytes_w;
  logic             dir_n, oob_n, mir_q, mir_now, step, last;

  assign main_m  = main_q & AMASK;
  assign aux_m   = aux_q & AMASK;
  assign dir_n   = ld_val_i[REG_W-1];
  assign bytes_w = {1'b0, ld_val_i[CNT_W-1:0]};
  assign oob_n   = aux_m >= AUX_SIZE;

  assign mir_now = (st_q == ST_WR) && !cnt_q[REG_W-1] && mir_q &&
                   ({{(REG_W-ADDR_W){1'b0}}, aux_q[ADDR_W-1:0]} < MIR_OFS);
  assign step    = ((st_q == ST_WR) && !mir_now) || (st_q == ST_MIR);
  assign last    = cnt_q[CNT_W-1:0] == BEAT_C;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      aux_q  <= '0;
      cnt_q  <= '0;
      st_q   <= ST_IDLE;
      oob_q  <= 1'b0;
      mir_q  <= 1'b0;
      hold_q <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (bytes_w == '0) begin
              main_q <= main_m;
              aux_q  <= aux_m;
              cnt_q  <= ld_val_i;
              irq_q  <= 1'b1;
            end else if (!dir_n && oob_n) begin
              main_q <= main_m + bytes_w;
              aux_q  <= aux_m + bytes_w;
              cnt_q  <= {dir_n, {CNT_W{1'b0}}};
              irq_q  <= 1'b1;
            end else begin
              main_q <= main_m;
              aux_q  <= aux_m;
              cnt_q  <= ld_val_i;
              oob_q  <= oob_n;
              mir_q  <= mode_i == MIR_MODE;
              busy_q <= 1'b1;
              st_q   <= ST_RD;
            end
          end else begin
            if (ld_main_i) main_q <= ld_val_i;
            if (ld_aux_i)  aux_q  <= ld_val_i;
            if (ld_cnt_i)  cnt_q  <= ld_val_i;
          end
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          hold_q <= mm_rdata_i;
          if (mir_now) st_q <= ST_MIR;
        end
        default: ;
      endcase
      if (step) begin
        main_q            <= main_q + BEAT_A;
        aux_q             <= aux_q + BEAT_A;
        cnt_q[CNT_W-1:0]  <= cnt_q[CNT_W-1:0] - BEAT_C;
        if (last) begin
          st_q   <= ST_IDLE;
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
        end else begin
          st_q <= ST_RD;
        end
      end
    end
  end
endmodule

// File: rtl/aux_dma_ports.sv
module aux_dma_ports
  import aux_dma_pkg::*;
#(
  parameter int          ADDR_W  = 26,
  parameter int          DATA_W  = 64,
  parameter logic [31:0] MIR_OFS = 32'h0040_0000
) (
  input  dma_st_t           st_i,
  input  logic              dir_i,
  input  logic              oob_i,
  input  logic [ADDR_W-1:0] main_i,
  input  logic [ADDR_W-1:0] aux_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [DATA_W-1:0] mm_rdata_i,
  input  logic [DATA_W-1:0] ax_rdata_i,
  output logic              mm_rd_o,
  output logic              mm_wr_o,
  output logic [ADDR_W-1:0] mm_addr_o,
  output logic [DATA_W-1:0] mm_wdata_o,
  output logic              ax_rd_o,
  output logic              ax_wr_o,
  output logic [ADDR_W-1:0] ax_addr_o,
  output logic [DATA_W-1:0] ax_wdata_o
);
  localparam logic [ADDR_W-1:0] MIR_A = ADDR_W'(MIR_OFS);

  always_comb begin
    mm_rd_o    = 1'b0;
    mm_wr_o    = 1'b0;
    ax_rd_o    = 1'b0;
    ax_wr_o    = 1'b0;
    mm_addr_o  = main_i;
    ax_addr_o  = aux_i;
    mm_wdata_o = oob_i ? '0 : ax_rdata_i;
    ax_wdata_o = mm_rdata_i;
    unique case (st_i)
      ST_RD: begin
        if (!dir_i)      mm_rd_o = 1'b1;
        else if (!oob_i) ax_rd_o = 1'b1;
      end
      ST_WR: begin
        if (!dir_i) ax_wr_o = 1'b1;
        else        mm_wr_o = 1'b1;
      end
      ST_MIR: begin
        ax_wr_o    = 1'b1;
        ax_addr_o  = aux_i + MIR_A;
        ax_wdata_o = hold_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aux_dma.sv
module aux_dma
  import aux_dma_pkg::*;
#(
  parameter int          REG_W    = 32,
  parameter int          ADDR_W   = 26,
  parameter int          DATA_W   = 64,
  parameter int          ALIGN_B  = 5,
  parameter logic [31:0] AUX_SIZE = 32'h0100_0000,
  parameter logic [31:0] MIR_OFS  = 32'h0040_0000,
  parameter logic [3:0]  MIR_MODE = 4'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [1:0]        reg_part_i,
  input  logic [REG_W-1:0]  reg_data_i,
  input  logic [3:0]        mode_i,
  output logic [REG_W-1:0]  main_addr_o,
  output logic [REG_W-1:0]  aux_addr_o,
  output logic [REG_W-1:0]  count_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              mm_rd_o,
  output logic              mm_wr_o,
  output logic [ADDR_W-1:0] mm_addr_o,
  output logic [DATA_W-1:0] mm_wdata_o,
  input  logic [DATA_W-1:0] mm_rdata_i,
  output logic              ax_rd_o,
  output logic              ax_wr_o,
  output logic [ADDR_W-1:0] ax_addr_o,
  output logic [DATA_W-1:0] ax_wdata_o,
  input  logic [DATA_W-1:0] ax_rdata_i
);
  logic             ld_main, ld_aux, ld_cnt, start, oob;
  logic [REG_W-1:0] ld_val;
  logic [DATA_W-1:0] hold;
  dma_st_t          st;

  aux_dma_host_if #(.REG_W(REG_W), .ALIGN_B(ALIGN_B)) u_host (
    .reg_wr_i   (reg_wr_i),
    .reg_sel_i  (reg_sel_i),
    .reg_part_i (reg_part_i),
    .reg_data_i (reg_data_i),
    .busy_i     (busy_o),
    .cur_main_i (main_addr_o),
    .cur_aux_i  (aux_addr_o),
    .cur_cnt_i  (count_o),
    .ld_main_o  (ld_main),
    .ld_aux_o   (ld_aux),
    .ld_cnt_o   (ld_cnt),
    .ld_val_o   (ld_val),
    .start_o    (start)
  );

  aux_dma_engine #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .AUX_SIZE(AUX_SIZE), .MIR_OFS(MIR_OFS), .MIR_MODE(MIR_MODE)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .ld_main_i  (ld_main),
    .ld_aux_i   (ld_aux),
    .ld_cnt_i   (ld_cnt),
    .ld_val_i   (ld_val),
    .mode_i     (mode_i),
    .mm_rdata_i (mm_rdata_i),
    .main_q     (main_addr_o),
    .aux_q      (aux_addr_o),
    .cnt_q      (count_o),
    .st_q       (st),
    .oob_q      (oob),
    .hold_q     (hold),
    .busy_q     (busy_o),
    .irq_q      (irq_o)
  );

  aux_dma_ports #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIR_OFS(MIR_OFS)) u_ports (
    .st_i       (st),
    .dir_i      (count_o[REG_W-1]),
    .oob_i      (oob),
    .main_i     (main_addr_o[ADDR_W-1:0]),
    .aux_i      (aux_addr_o[ADDR_W-1:0]),
    .hold_i     (hold),
    .mm_rdata_i (mm_rdata_i),
    .ax_rdata_i (ax_rdata_i),
    .mm_rd_o    (mm_rd_o),
    .mm_wr_o    (mm_wr_o),
    .mm_addr_o  (mm_addr_o),
    .mm_wdata_o (mm_wdata_o),
    .ax_rd_o    (ax_rd_o),
    .ax_wr_o    (ax_wr_o),
    .ax_addr_o  (ax_addr_o),
    .ax_wdata_o (ax_wdata_o)
  );
endmodule

// File: rtl/aux_dma_chk.sv
module aux_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy_o,
  input logic        irq_o,
  input logic        mm_rd_o,
  input logic        mm_wr_o,
  input logic        ax_rd_o,
  input logic        ax_wr_o,
  input logic [31:0] main_addr_o,
  input logic [31:0] aux_addr_o,
  input logic [31:0] count_o
);
  // R4: a main read is followed by the auxiliary write of the same beat
  a_r4_main_rd_then_aux_wr: assert property (@(posedge clk) disable iff (rst)
    mm_rd_o |=> (ax_wr_o && !mm_wr_o));
  // R4: an auxiliary read is followed by the main write
  a_r4_aux_rd_then_main_wr: assert property (@(posedge clk) disable iff (rst)
    ax_rd_o |=> (mm_wr_o && !ax_wr_o));
  // R4: at most one port action per cycle
  a_r4_one_port_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mm_rd_o, mm_wr_o, ax_rd_o, ax_wr_o}));
  // R6: ports are quiet whenever the engine is not busy
  a_r6_idle_ports_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !(mm_rd_o || mm_wr_o || ax_rd_o || ax_wr_o));
  // R6: completion pulse never overlaps busy
  a_r6_irq_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && busy_o));
  // R6: busy only ends with a completion pulse
  a_r6_busy_fall_irq: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> irq_o);
  // R5: the count is exhausted at completion
  a_r5_count_zero_at_irq: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (count_o[30:0] == 31'd0));
  // R1: addresses stay beat aligned
  a_r1_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    (main_addr_o[2:0] == 3'd0) && (aux_addr_o[2:0] == 3'd0));
endmodule

bind aux_dma aux_dma_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .mm_rd_o     (mm_rd_o),
  .mm_wr_o     (mm_wr_o),
  .ax_rd_o     (ax_rd_o),
  .ax_wr_o     (ax_wr_o),
  .main_addr_o (main_addr_o),
  .aux_addr_o  (aux_addr_o),
  .count_o     (count_o)
);

// File: tb/aux_dma_tb_top.sv
module aux_dma_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] AUX_SZ     = 32'h0100_0000;
  localparam logic [31:0] MIRO       = 32'h0040_0000;
  localparam logic [31:0] M26        = 32'h03FF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0, reg_part = '0;
  logic [31:0] reg_data = '0;
  logic [3:0]  cur_mode = '0;
  logic [31:0] main_addr, aux_addr, count;
  logic        busy, irq, mm_rd, mm_wr, ax_rd, ax_wr;
  logic [25:0] mm_addr, ax_addr;
  logic [63:0] mm_wdata, ax_wdata;
  logic [63:0] mm_rdata = '0, ax_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_dma dut_i (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_part_i(reg_part), .reg_data_i(reg_data), .mode_i(cur_mode),
    .main_addr_o(main_addr), .aux_addr_o(aux_addr), .count_o(count),
    .busy_o(busy), .irq_o(irq),
    .mm_rd_o(mm_rd), .mm_wr_o(mm_wr), .mm_addr_o(mm_addr),
    .mm_wdata_o(mm_wdata), .mm_rdata_i(mm_rdata),
    .ax_rd_o(ax_rd), .ax_wr_o(ax_wr), .ax_addr_o(ax_addr),
    .ax_wdata_o(ax_wdata), .ax_rdata_i(ax_rdata)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory models
  logic [63:0] mmem [int];
  logic [63:0] amem [int];

  function automatic logic [63:0] main_val(input logic [25:0] a);
    int k = int'(a >> 3);
    if (mmem.exists(k)) return mmem[k];
    return {6'h11, a, ~{6'h0, a}};
  endfunction

  function automatic logic [63:0] aux_val(input logic [25:0] a);
    int k = int'(a >> 3);
    if (amem.exists(k)) return amem[k];
    return {~{6'h0, a}, 6'h2A, a};
  endfunction

  always @(posedge clk) begin
    if (mm_rd) mm_rdata <= main_val(mm_addr);
    if (ax_rd) ax_rdata <= aux_val(ax_addr);
    if (mm_wr) mmem[int'(mm_addr >> 3)] = mm_wdata;
    if (ax_wr) amem[int'(ax_addr >> 3)] = ax_wdata;
  end

  // reference model
  typedef struct { int kind; logic [25:0] addr; logic [63:0] data; } ev_t;
  ev_t evq[$];
  int  left = 0;
  bit  fire = 1'b0;
  bit  last_busy = 1'b0;
  logic [31:0] s_main = '0, s_aux = '0, s_cnt = '0;

  task automatic push_ev(input int kind, input logic [31:0] a, input logic [63:0] d);
    ev_t e;
    e.kind = kind; e.addr = a[25:0]; e.data = d;
    evq.push_back(e);
  endtask

  task automatic plan(input logic [31:0] cw);
    logic [31:0] mm, ax, bytes;
    bit dir, oob;
    int n = 0;
    bytes = {1'b0, cw[30:0]};
    dir   = cw[31];
    mm    = s_main & M26;
    ax    = s_aux & M26;
    oob   = ax >= AUX_SZ;
    if (bytes != 0 && !(!dir && oob)) begin
      for (int b = 0; b < int'(bytes / 8); b++) begin
        logic [31:0] a, x;
        logic [63:0] d;
        a = mm + 32'(8*b);
        x = ax + 32'(8*b);
        if (!dir) begin
          d = main_val(a[25:0]);
          push_ev(0, a, 64'h0);
          push_ev(3, x, d);
          n += 2;
          if (cur_mode == 4'd4 && x < MIRO) begin
            push_ev(3, x + MIRO, d);
            n++;
          end
        end else begin
          d = oob ? 64'h0 : aux_val(x[25:0]);
          if (!oob) push_ev(1, x, 64'h0);
          push_ev(2, a, d);
          n += 2;
        end
      end
    end
    left   = n;
    fire   = (n == 0);
    s_main = mm + bytes;
    s_aux  = ax + bytes;
    s_cnt  = {dir, 31'b0};
  endtask

  task automatic hw(input logic [1:0] sel, input logic [1:0] part, input logic [31:0] d);
    logic [31:0] cur, nv;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_part = part; reg_data = d;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    if (!last_busy && sel != 2'd3 && part != 2'd3) begin
      cur = (sel == 0) ? s_main : (sel == 1) ? s_aux : s_cnt;
      if (part == 0)      nv = {cur[31:16], d[15:5], 5'b0};
      else if (part == 1) nv = {d[15:0], cur[15:0]};
      else                nv = {d[31:5], 5'b0};
      if (sel == 0) s_main = nv;
      else if (sel == 1) s_aux = nv;
      else begin
        s_cnt = nv;
        if (part != 1) plan(nv);
      end
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (left > 0 || fire);
    @(negedge clk);
    chk(evq.size() == 0, "R6 all beats issued", 64'(evq.size()), 64'h0);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      bit eb, ei;
      eb = left > 0;
      ei = (left == 0) && fire;
      chk(busy == eb, "R6 busy", 64'(busy), 64'(eb));
      chk(irq == ei, "R6 irq", 64'(irq), 64'(ei));
      if (eb) begin
        left--;
        if (left == 0) fire = 1'b1;
      end else if (ei) begin
        fire = 1'b0;
      end
      last_busy = eb;
      if (mm_rd || mm_wr || ax_rd || ax_wr) begin
        int k;
        logic [25:0] a;
        logic [63:0] d;
        k = mm_rd ? 0 : ax_rd ? 1 : mm_wr ? 2 : 3;
        a = (k == 0 || k == 2) ? mm_addr : ax_addr;
        d = (k == 2) ? mm_wdata : (k == 3) ? ax_wdata : 64'h0;
        if (evq.size() == 0) begin
          chk(1'b0, "R4 unexpected port action", 64'(k), 64'hFF);
        end else begin
          ev_t e;
          e = evq.pop_front();
          chk(k == e.kind, "R4 port kind", 64'(k), 64'(e.kind));
          chk(a == e.addr, "R4 port addr", 64'(a), 64'(e.addr));
          chk(d == e.data, "R4 port data", d, e.data);
        end
      end
      if (!eb) begin
        chk(main_addr == s_main, "R5 main addr", 64'(main_addr), 64'(s_main));
        chk(aux_addr == s_aux, "R5 aux addr", 64'(aux_addr), 64'(s_aux));
        chk(count == s_cnt, "R5 count", 64'(count), 64'(s_cnt));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(main_addr == 0 && aux_addr == 0 && count == 0, "R12 regs zero", 64'(main_addr | aux_addr | count), 64'h0);
    chk(!busy && !irq, "R12 busy/irq low", {62'h0, busy, irq}, 64'h0);
    chk(!(mm_rd | mm_wr | ax_rd | ax_wr), "R12 ports quiet", 64'({mm_rd, mm_wr, ax_rd, ax_wr}), 64'h0);

    // R1 alignment of halves and R2 high count write does not start
    hw(2'd0, 2'd0, 32'h0000_1237);
    chk(main_addr == 32'h0000_1220, "R1 low half aligned", 64'(main_addr), 64'h1220);
    hw(2'd0, 2'd1, 32'h0000_0C00);
    chk(main_addr == 32'h0C00_1220, "R1 high half kept low", 64'(main_addr), 64'h0C00_1220);
    hw(2'd1, 2'd2, 32'h0000_803F);
    chk(aux_addr == 32'h0000_8020, "R1 full aligned", 64'(aux_addr), 64'h8020);
    hw(2'd2, 2'd1, 32'h0000_0000);
    @(negedge clk);
    chk(!busy && !irq, "R2 high count write no start", {62'h0, busy, irq}, 64'h0);
    hw(2'd3, 2'd0, 32'h0000_FFFF);
    hw(2'd0, 2'd3, 32'h0000_FFFF);
    chk(main_addr == 32'h0C00_1220, "R2 select/part 3 ignored", 64'(main_addr), 64'h0C00_1220);

    // R3 R4 R5: main to aux, 64 bytes, main address mirrored to 26 bits
    hw(2'd2, 2'd0, 32'h0000_0047);
    wait_idle();
    chk(main_addr == 32'h0000_1260, "R3 main masked to 26 bits", 64'(main_addr), 64'h1260);
    chk(amem.exists(32'h8020 >> 3) && amem[32'h8020 >> 3] == main_val(26'h1220), "R4 aux holds copied data",
        amem[32'h8020 >> 3], main_val(26'h1220));

    // R4 aux to main via full count write
    hw(2'd0, 2'd2, 32'h0400_4000);
    hw(2'd1, 2'd2, 32'h0000_A000);
    hw(2'd2, 2'd2, 32'h8000_0020);
    wait_idle();
    chk(count == 32'h8000_0000, "R5 dir kept, count zero", 64'(count), 64'h8000_0000);

    // R9 mode 4 mirror, crossing the 4 MB boundary
    cur_mode = 4'd4;
    hw(2'd0, 2'd2, 32'h0000_2000);
    hw(2'd1, 2'd2, 32'h003F_FFE0);
    hw(2'd2, 2'd2, 32'h0000_0040);
    wait_idle();
    chk(amem.exists(32'h007F_FFE0 >> 3), "R9 mirror written", 64'(amem.exists(32'h007F_FFE0 >> 3)), 64'h1);

    // R9 no mirror in another mode
    cur_mode = 4'd3;
    hw(2'd1, 2'd2, 32'h0010_0000);
    hw(2'd2, 2'd2, 32'h0000_0020);
    wait_idle();
    chk(!amem.exists(32'h0050_0000 >> 3), "R9 no mirror in mode 3", 64'(amem.exists(32'h0050_0000 >> 3)), 64'h0);
    cur_mode = 4'd0;

    // R7 aux to main out of range writes zeros
    hw(2'd0, 2'd2, 32'h0000_6000);
    hw(2'd1, 2'd2, 32'h0180_0000);
    hw(2'd2, 2'd2, 32'h8000_0040);
    wait_idle();
    chk(mmem.exists(32'h6038 >> 3) && mmem[32'h6038 >> 3] == 64'h0, "R7 zeros written", mmem[32'h6038 >> 3], 64'h0);

    // R8 main to aux out of range: no access, immediate completion
    hw(2'd0, 2'd2, 32'h0000_7000);
    hw(2'd1, 2'd2, 32'h0200_0000);
    hw(2'd2, 2'd2, 32'h0000_0100);
    chk(!busy, "R8 busy stays low", 64'(busy), 64'h0);
    wait_idle();
    chk(aux_addr == 32'h0200_0100, "R8 aux advanced by count", 64'(aux_addr), 64'h0200_0100);

    // R10 zero count
    hw(2'd1, 2'd2, 32'h0000_1000);
    hw(2'd2, 2'd2, 32'h0000_001F);
    wait_idle();

    // R11 writes during a long copy are ignored
    hw(2'd0, 2'd2, 32'h0000_8000);
    hw(2'd1, 2'd2, 32'h0000_C000);
    hw(2'd2, 2'd0, 32'h0000_0100);
    hw(2'd0, 2'd2, 32'h0123_4560);
    hw(2'd2, 2'd0, 32'h0000_0040);
    wait_idle();
    chk(main_addr == 32'h0000_8100, "R11 busy writes ignored", 64'(main_addr), 64'h8100);
    repeat (4) @(negedge clk);
    chk(!busy && !irq, "R11 no second start", {62'h0, busy, irq}, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule